// File: doc/BRIEF.md
# Message-Out Byte Parser

This block interprets the message bytes that an initiator hands over while the bus is in the message-out phase. A controller starts a move by giving a byte count and a buffer address. The parser then pulls bytes from a valid/ready stream. Each accepted byte lowers the count and raises the address by one. Parsing ends when the count reaches zero.

The parser recognises disconnect, no-operation, identify, queue-tag and extended negotiation messages. Its results are held in registers:

- the bus phase that comes next;
- a connected flag;
- the logical unit number;
- an accumulated tag with a valid flag;
- a flag for queue-tag kinds that are accepted but not fully supported;
- a flag for a count that ran out in the middle of a message;
- a copy of the most recent byte.

Sync and wide negotiation requests are read and then dropped. The parser does not answer them. Any message it does not know makes it stop parsing. It then switches to message-in and pushes a reject byte into the message-in buffer. It also records that the phase after that message must be command.

The bytes that follow an opening byte are kept in the sequencer's state. They are never decoded as new messages.

Top module: `msgout_parser`

## Requirements
- R1: When `start` is high while `busy` is low and `start_cnt` is nonzero, the next cycle shows the following. `busy`=1, `remaining`=`start_cnt`, `rd_addr`=`start_addr`, phase=3'b110 (message-out) and `connected`=1. `trunc_err` and `tag_unsupported` are cleared. A start with a zero count changes nothing, and `busy` and `in_ready` stay 0.
- R2: Every byte accepted (`in_valid`&&`in_ready` at a clock edge) lowers `remaining` by 1 and raises `rd_addr` by 1. With no accepted byte and no start, both hold their values. When `remaining` reaches 0, `busy` and `in_ready` fall.
- R3: Byte 8'h00 clears `connected` and sets phase to 3'b000.
- R4: Byte 8'h08 sets phase to 3'b010 (command).
- R5: Byte 8'h01 opens an extended message. The next byte is a length and is ignored. The byte after that is a code.
  - Code 8'h01 makes the parser consume exactly 2 more bytes.
  - Code 8'h03 makes it consume exactly 1 more byte.
  - None of these bytes changes phase, LUN or tag. The byte after them is decoded as a new message.
- R6: Bytes 8'h20, 8'h21 and 8'h22 take the next byte and OR it into `tag`, and they set `tag_valid`. Bytes 8'h21 and 8'h22 also set `tag_unsupported`. Byte 8'h20 does not.
- R7: A byte with bit 7 set loads its bits [2:0] into `lun` and sets phase to 3'b010.
- R8: The parser rejects two cases: an opening byte with bit 7 clear that matches no code in R3–R6, and an extended code other than 8'h01 or 8'h03. A reject does all of the following:
  - `msgin_push` is high for one cycle, with `msgin_byte`=8'h07;
  - phase becomes 3'b111 (message-in);
  - `post_action` becomes 2'd0 (command), where its reset value is 2'd1 (disconnect);
  - parsing stops, so `busy` falls and `remaining` keeps the count of unread bytes.
- R9: `first_byte` takes the value of every accepted byte in the cycle after it is accepted.
- R10: If `remaining` reaches 0 after the opening byte of an extended or queue-tag message, before that message is complete, `trunc_err` is set and `busy` falls.
- R11: After reset the outputs are as follows: `busy`=0, `in_ready`=0, phase=0, `connected`=0, `lun`=0, `tag`=0, `tag_valid`=0, `first_byte`=0, `msgin_push`=0, `post_action`=1, and both flags 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, already released in step with `clk` |
| start | input | 1 | Begin a move (accepted only when idle) |
| start_cnt | input | CNT_W | Byte count of the move |
| start_addr | input | ADDR_W | Address of the first byte |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_ready | output | 1 | Parser accepts a byte this cycle |
| rd_addr | output | ADDR_W | Address of the next byte |
| remaining | output | CNT_W | Bytes left in the move |
| busy | output | 1 | A move is in progress |
| phase | output | 3 | Next bus phase |
| connected | output | 1 | Connection still held |
| lun | output | 3 | Selected logical unit |
| tag | output | 8 | Accumulated queue tag |
| tag_valid | output | 1 | A queue tag was received |
| tag_unsupported | output | 1 | Head-of-queue or ordered tag seen in this move |
| trunc_err | output | 1 | Count ran out inside a multi-byte message |
| first_byte | output | 8 | Copy of the last accepted byte |
| msgin_push | output | 1 | One-cycle request to queue a reject byte |
| msgin_byte | output | 8 | Byte to queue on `msgin_push` |
| post_action | output | 2 | Phase to take after message-in (0 command, 1 disconnect, 2 data-out, 3 data-in) |

## Verification
Every result is registered at the same edge that accepts the byte or the start. So `remaining`, `rd_addr`, `first_byte`, phase, LUN, tag, the flags and `msgin_push` all become visible one cycle after that edge. The driver changes inputs 1 ns after a rising edge and inspects the results at that point once the accepting edge has passed. The scoreboard monitor samples on the falling edge: it records a handshake seen there and compares the popped byte, count and address on the next falling edge. Reject pushes are matched on the falling edge they appear in, against a separate queue of expected rejects.

// File: rtl/msgout_pkg.sv
`timescale 1ns/1ps
package msgout_pkg;

  typedef enum logic [2:0] {
    PH_DOUT = 3'd0,
    PH_DIN  = 3'd1,
    PH_CMD  = 3'd2,
    PH_STAT = 3'd3,
    PH_MOUT = 3'd6,
    PH_MIN  = 3'd7
  } phase_e;

  typedef enum logic [1:0] {
    ACT_CMD  = 2'd0,
    ACT_DISC = 2'd1,
    ACT_DOUT = 2'd2,
    ACT_DIN  = 2'd3
  } act_e;

  typedef enum logic [2:0] {
    CL_DISC, CL_NOP, CL_EXT, CL_TAG, CL_TAG_PART, CL_IDENT, CL_BAD
  } cls_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_OP, ST_XLEN, ST_XCODE, ST_SKIP, ST_TAG
  } st_e;

  localparam logic [7:0] MB_DISC   = 8'h00;
  localparam logic [7:0] MB_EXT    = 8'h01;
  localparam logic [7:0] MB_NOP    = 8'h08;
  localparam logic [7:0] MB_TAG_S  = 8'h20;
  localparam logic [7:0] MB_TAG_H  = 8'h21;
  localparam logic [7:0] MB_TAG_O  = 8'h22;
  localparam logic [7:0] XC_SYNC   = 8'h01;
  localparam logic [7:0] XC_WIDE   = 8'h03;
  localparam logic [7:0] MB_REJECT = 8'h07;

  localparam int SKIP_W    = 2;
  localparam int SYNC_SKIP = 2;
  localparam int WIDE_SKIP = 1;

endpackage

// File: rtl/msgout_classify.sv
`timescale 1ns/1ps
module msgout_classify
  import msgout_pkg::*;
(
  input  logic [7:0] byte_i,
  output cls_e       cls_o
);

  always_comb begin
    if (byte_i[7])                                     cls_o = CL_IDENT;
    else if (byte_i == MB_DISC)                        cls_o = CL_DISC;
    else if (byte_i == MB_NOP)                         cls_o = CL_NOP;
    else if (byte_i == MB_EXT)                         cls_o = CL_EXT;
    else if (byte_i == MB_TAG_S)                       cls_o = CL_TAG;
    else if (byte_i == MB_TAG_H || byte_i == MB_TAG_O) cls_o = CL_TAG_PART;
    else                                               cls_o = CL_BAD;
  end

endmodule

// File: rtl/msgout_xfer_ctr.sv
`timescale 1ns/1ps
module msgout_xfer_ctr #(
  parameter int CNT_W  = 24,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CNT_W-1:0]  load_cnt,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              step,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o
);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              en;

  assign en = load | step;

  always_comb begin
    cnt_d  = cnt_q;
    addr_d = addr_q;
    if (load) begin
      cnt_d  = load_cnt;
      addr_d = load_addr;
    end else if (step) begin
      cnt_d  = cnt_q - 1'b1;
      addr_d = addr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      addr_q <= '0;
    end else if (en) begin
      cnt_q  <= cnt_d;
      addr_q <= addr_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign addr_o = addr_q;
  assign last_o = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/msgout_seq.sv
`timescale 1ns/1ps
module msgout_seq
  import msgout_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic       fire,
  input  logic [7:0] byte_i,
  input  cls_e       cls_i,
  input  logic       last_i,
  output logic       active_o,
  output logic       ev_disc,
  output logic       ev_cmd,
  output logic       ev_ident,
  output logic       ev_part,
  output logic       ev_tag,
  output logic       ev_reject,
  output logic       ev_trunc
);

  st_e               st_q, st_d;
  logic [SKIP_W-1:0] skip_q, skip_d;
  logic              en;

  assign en = go | fire;

  always_comb begin
    st_d      = st_q;
    skip_d    = skip_q;
    ev_disc   = 1'b0;
    ev_cmd    = 1'b0;
    ev_ident  = 1'b0;
    ev_part   = 1'b0;
    ev_tag    = 1'b0;
    ev_reject = 1'b0;
    ev_trunc  = 1'b0;
    case (st_q)
      ST_IDLE: if (go) st_d = ST_OP;
      ST_OP: if (fire) begin
        case (cls_i)
          CL_DISC:     ev_disc = 1'b1;
          CL_NOP:      ev_cmd  = 1'b1;
          CL_IDENT:    ev_ident = 1'b1;
          CL_EXT:      st_d = ST_XLEN;
          CL_TAG:      st_d = ST_TAG;
          CL_TAG_PART: begin st_d = ST_TAG; ev_part = 1'b1; end
          default:     ev_reject = 1'b1;
        endcase
      end
      ST_XLEN: if (fire) st_d = ST_XCODE;
      ST_XCODE: if (fire) begin
        if (byte_i == XC_SYNC) begin
          skip_d = SKIP_W'(SYNC_SKIP);
          st_d   = ST_SKIP;
        end else if (byte_i == XC_WIDE) begin
          skip_d = SKIP_W'(WIDE_SKIP);
          st_d   = ST_SKIP;
        end else begin
          ev_reject = 1'b1;
        end
      end
      ST_SKIP: if (fire) begin
        skip_d = skip_q - 1'b1;
        st_d   = (skip_q == SKIP_W'(1)) ? ST_OP : ST_SKIP;
      end
      ST_TAG: if (fire) begin
        ev_tag = 1'b1;
        st_d   = ST_OP;
      end
      default: st_d = ST_IDLE;
    endcase
    if (fire) begin
      if (ev_reject) begin
        st_d = ST_IDLE;
      end else if (last_i) begin
        ev_trunc = (st_d != ST_OP);
        st_d     = ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      skip_q <= '0;
    end else if (en) begin
      st_q   <= st_d;
      skip_q <= skip_d;
    end
  end

  assign active_o = (st_q != ST_IDLE);

endmodule

// File: rtl/msgout_parser.sv
`timescale 1ns/1ps
module msgout_parser
  import msgout_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  start_cnt,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  output logic              in_ready,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  remaining,
  output logic              busy,
  output logic [2:0]        phase,
  output logic              connected,
  output logic [2:0]        lun,
  output logic [7:0]        tag,
  output logic              tag_valid,
  output logic              tag_unsupported,
  output logic              trunc_err,
  output logic [7:0]        first_byte,
  output logic              msgin_push,
  output logic [7:0]        msgin_byte,
  output logic [1:0]        post_action
);

  logic go, fire, last, active;
  logic ev_disc, ev_cmd, ev_ident, ev_part, ev_tag, ev_reject, ev_trunc;
  cls_e cls;

  assign go   = start & ~active & (start_cnt != '0);
  assign fire = in_valid & active;

  msgout_classify u_cls (.byte_i(in_data), .cls_o(cls));

  msgout_xfer_ctr #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .load(go), .load_cnt(start_cnt),
    .load_addr(start_addr), .step(fire), .cnt_o(remaining),
    .addr_o(rd_addr), .last_o(last)
  );

  msgout_seq u_seq (
    .clk(clk), .rst_n(rst_n), .go(go), .fire(fire), .byte_i(in_data),
    .cls_i(cls), .last_i(last), .active_o(active),
    .ev_disc(ev_disc), .ev_cmd(ev_cmd), .ev_ident(ev_ident),
    .ev_part(ev_part), .ev_tag(ev_tag), .ev_reject(ev_reject),
    .ev_trunc(ev_trunc)
  );

  logic [2:0] phase_q, phase_d;
  logic       conn_q, conn_d;
  logic [2:0] lun_q, lun_d;
  logic [7:0] tag_q, tag_d;
  logic       tagv_q, tagv_d;
  logic       part_q, part_d;
  logic       trunc_q, trunc_d;
  logic [7:0] fb_q, fb_d;
  logic       push_q, push_d;
  logic [7:0] mib_q, mib_d;
  logic [1:0] act_q, act_d;
  logic       upd_en;

  assign upd_en = go | fire | push_q;

  always_comb begin
    phase_d = phase_q;
    conn_d  = conn_q;
    lun_d   = lun_q;
    tag_d   = tag_q;
    tagv_d  = tagv_q;
    part_d  = part_q;
    trunc_d = trunc_q;
    fb_d    = fb_q;
    push_d  = 1'b0;
    mib_d   = mib_q;
    act_d   = act_q;
    if (go) begin
      phase_d = PH_MOUT;
      conn_d  = 1'b1;
      part_d  = 1'b0;
      trunc_d = 1'b0;
    end
    if (fire) fb_d = in_data;
    if (ev_disc) begin
      conn_d  = 1'b0;
      phase_d = PH_DOUT;
    end
    if (ev_cmd) phase_d = PH_CMD;
    if (ev_ident) begin
      lun_d   = in_data[2:0];
      phase_d = PH_CMD;
    end
    if (ev_part) part_d = 1'b1;
    if (ev_tag) begin
      tag_d  = tag_q | in_data;
      tagv_d = 1'b1;
    end
    if (ev_reject) begin
      phase_d = PH_MIN;
      act_d   = ACT_CMD;
      push_d  = 1'b1;
      mib_d   = MB_REJECT;
    end
    if (ev_trunc) trunc_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_DOUT;
      conn_q  <= 1'b0;
      lun_q   <= '0;
      tag_q   <= '0;
      tagv_q  <= 1'b0;
      part_q  <= 1'b0;
      trunc_q <= 1'b0;
      fb_q    <= '0;
      push_q  <= 1'b0;
      mib_q   <= '0;
      act_q   <= ACT_DISC;
    end else if (upd_en) begin
      phase_q <= phase_d;
      conn_q  <= conn_d;
      lun_q   <= lun_d;
      tag_q   <= tag_d;
      tagv_q  <= tagv_d;
      part_q  <= part_d;
      trunc_q <= trunc_d;
      fb_q    <= fb_d;
      push_q  <= push_d;
      mib_q   <= mib_d;
      act_q   <= act_d;
    end
  end

  assign in_ready        = active;
  assign busy            = active;
  assign phase           = phase_q;
  assign connected       = conn_q;
  assign lun             = lun_q;
  assign tag             = tag_q;
  assign tag_valid       = tagv_q;
  assign tag_unsupported = part_q;
  assign trunc_err       = trunc_q;
  assign first_byte      = fb_q;
  assign msgin_push      = push_q;
  assign msgin_byte      = mib_q;
  assign post_action     = act_q;

endmodule

// File: rtl/msgout_parser_chk.sv
`timescale 1ns/1ps
module msgout_parser_chk #(
  parameter int CNT_W  = 24,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [CNT_W-1:0]  start_cnt,
  input logic              in_valid,
  input logic              in_ready,
  input logic [7:0]        in_data,
  input logic [CNT_W-1:0]  remaining,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              busy,
  input logic [2:0]        phase,
  input logic              connected,
  input logic              trunc_err,
  input logic [7:0]        first_byte,
  input logic              msgin_push,
  input logic [7:0]        msgin_byte
);

  logic hs;
  assign hs = in_valid && in_ready;

  a_r1_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && start_cnt != '0) |=> (busy && phase == 3'b110 && connected && remaining == $past(start_cnt)));

  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    hs |=> (remaining == $past(remaining) - 1'b1) && (rd_addr == $past(rd_addr) + 1'b1));

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!hs && !start) |=> $stable(remaining) && $stable(rd_addr));

  a_r2_busy_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> remaining != '0);

  a_r3_disconnect_phase: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(connected) |-> phase == 3'b000);

  a_r8_reject_push: assert property (@(posedge clk) disable iff (!rst_n)
    msgin_push |-> (msgin_byte == 8'h07) && (phase == 3'b111) && !busy);

  a_r8_push_single: assert property (@(posedge clk) disable iff (!rst_n)
    msgin_push |=> !msgin_push);

  a_r9_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    hs |=> first_byte == $past(in_data));

  a_r10_trunc_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trunc_err) |-> !busy && $past(busy));

endmodule

bind msgout_parser msgout_parser_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .start_cnt(start_cnt),
  .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
  .remaining(remaining), .rd_addr(rd_addr), .busy(busy), .phase(phase),
  .connected(connected), .trunc_err(trunc_err), .first_byte(first_byte),
  .msgin_push(msgin_push), .msgin_byte(msgin_byte)
);

// File: tb/msgout_parser_bench.sv
`timescale 1ns/1ps
module msgout_parser_bench;

  localparam int CW = 24;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic [CW-1:0] start_cnt;
  logic [AW-1:0] start_addr;
  logic          in_valid;
  logic [7:0]    in_data;
  logic          in_ready;
  logic [AW-1:0] rd_addr;
  logic [CW-1:0] remaining;
  logic          busy, connected, tag_valid, tag_unsupported, trunc_err, msgin_push;
  logic [2:0]    phase, lun;
  logic [7:0]    tag, first_byte, msgin_byte;
  logic [1:0]    post_action;

  always #2 clk = ~clk;

  msgout_parser u_msgout_parser (
    .clk(clk), .rst_n(rst_n), .start(start), .start_cnt(start_cnt),
    .start_addr(start_addr), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .rd_addr(rd_addr), .remaining(remaining),
    .busy(busy), .phase(phase), .connected(connected), .lun(lun),
    .tag(tag), .tag_valid(tag_valid), .tag_unsupported(tag_unsupported),
    .trunc_err(trunc_err), .first_byte(first_byte), .msgin_push(msgin_push),
    .msgin_byte(msgin_byte), .post_action(post_action)
  );

  int nvec = 0;
  int nerr = 0;
  bit finished = 0;

  typedef struct {
    logic [7:0]    b;
    logic [CW-1:0] rem;
    logic [AW-1:0] addr;
  } item_t;
  item_t      sbq[$];
  logic [7:0] rejq[$];
  logic [CW-1:0] cur_cnt;
  logic [AW-1:0] cur_addr;
  bit pend = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (pend) begin
      if (sbq.size() == 0) begin
        check("R2 unexpected byte accepted", 32'd1, 32'd0);
      end else begin
        item_t it;
        it = sbq.pop_front();
        check("R9 first_byte mirror", {24'd0, first_byte}, {24'd0, it.b});
        check("R2 remaining step", {8'd0, remaining}, {8'd0, it.rem});
        check("R2 rd_addr step", rd_addr, it.addr);
      end
    end
    if (rst_n && msgin_push) begin
      if (rejq.size() == 0) check("R8 unexpected push", 32'd1, 32'd0);
      else check("R8 reject byte", {24'd0, msgin_byte}, {24'd0, rejq.pop_front()});
    end
    pend = rst_n && in_valid && in_ready;
  end

  task automatic begin_move(input int cnt, input logic [AW-1:0] a);
    start = 1'b1;
    start_cnt = CW'(cnt);
    start_addr = a;
    @(posedge clk); #1;
    start = 1'b0;
    cur_cnt = CW'(cnt);
    cur_addr = a;
  endtask

  task automatic put(input logic [7:0] b, input bit rej);
    item_t it;
    it.b = b;
    it.rem = cur_cnt - 1'b1;
    it.addr = cur_addr + 1'b1;
    sbq.push_back(it);
    if (rej) rejq.push_back(8'h07);
    cur_cnt = cur_cnt - 1'b1;
    cur_addr = cur_addr + 1'b1;
    in_valid = 1'b1;
    in_data = b;
    while (!in_ready) begin @(posedge clk); #1; end
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic report;
    if (sbq.size() != 0 || rejq.size() != 0)
      check("R8/R9 scoreboard drained", 32'(sbq.size() + rejq.size()), 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nerr++;
      $display("FAIL watchdog expired");
      report();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; start_cnt = '0; start_addr = '0;
    in_valid = 1'b0; in_data = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(1);
    // R11 reset state
    check("R11 busy", {31'd0, busy}, 32'd0);
    check("R11 in_ready", {31'd0, in_ready}, 32'd0);
    check("R11 phase", {29'd0, phase}, 32'd0);
    check("R11 connected", {31'd0, connected}, 32'd0);
    check("R11 tag/valid/lun", {20'd0, tag, tag_valid, lun}, 32'd0);
    check("R11 flags", {30'd0, tag_unsupported, trunc_err}, 32'd0);
    check("R11 first_byte/push", {23'd0, first_byte, msgin_push}, 32'd0);
    check("R11 post_action", {30'd0, post_action}, 32'd1);

    // R1 start load
    begin_move(3, 32'h1000);
    check("R1 busy", {31'd0, busy}, 32'd1);
    check("R1 remaining", {8'd0, remaining}, 32'd3);
    check("R1 rd_addr", rd_addr, 32'h1000);
    check("R1 phase msg-out", {29'd0, phase}, 32'd6);
    check("R1 connected", {31'd0, connected}, 32'd1);
    // R7 identify then R6 simple tag
    put(8'h85, 0);
    check("R7 lun", {29'd0, lun}, 32'd5);
    check("R7 phase cmd", {29'd0, phase}, 32'd2);
    put(8'h20, 0);
    check("R6 tag not yet loaded", {31'd0, tag_valid}, 32'd0);
    put(8'h3C, 0);
    check("R6 tag", {24'd0, tag}, 32'h3C);
    check("R6 tag_valid", {31'd0, tag_valid}, 32'd1);
    check("R6 simple not unsupported", {31'd0, tag_unsupported}, 32'd0);
    check("R2 busy drops at zero", {30'd0, busy, in_ready}, 32'd0);

    // R6 OR accumulation
    begin_move(2, 32'h2000);
    put(8'h20, 0); put(8'h03, 0);
    check("R6 tag OR", {24'd0, tag}, 32'h3F);
    check("R6 unsupported clear", {31'd0, tag_unsupported}, 32'd0);
    begin_move(4, 32'h2100);
    put(8'h21, 0); put(8'h40, 0);
    check("R6 head tag OR", {24'd0, tag}, 32'h7F);
    check("R6 head unsupported", {31'd0, tag_unsupported}, 32'd1);
    put(8'h22, 0); put(8'h80, 0);
    check("R6 ordered tag OR", {24'd0, tag}, 32'hFF);
    check("R6 tag byte not identify", {29'd0, lun}, 32'd5);

    // R5 sync negotiation skips 2, then R4
    begin_move(6, 32'h3000);
    put(8'h01, 0); put(8'h03, 0); put(8'h01, 0); put(8'hAA, 0); put(8'hBB, 0);
    check("R5 sync phase unchanged", {29'd0, phase}, 32'd6);
    check("R5 sync lun/tag unchanged", {21'd0, lun, tag}, {21'd0, 3'd5, 8'hFF});
    check("R5 still busy", {31'd0, busy}, 32'd1);
    put(8'h08, 0);
    check("R4 nop phase cmd", {29'd0, phase}, 32'd2);
    check("R5 no truncation", {31'd0, trunc_err}, 32'd0);

    // R5 wide negotiation skips 1, then R3
    begin_move(5, 32'h4000);
    put(8'h01, 0); put(8'h02, 0); put(8'h03, 0); put(8'h8F, 0);
    check("R5 wide skip not identify", {29'd0, lun}, 32'd5);
    check("R5 wide phase unchanged", {29'd0, phase}, 32'd6);
    put(8'h00, 0);
    check("R3 disconnect clears connected", {31'd0, connected}, 32'd0);
    check("R3 disconnect phase", {29'd0, phase}, 32'd0);

    // R8 unknown opening byte
    check("R8 post_action before reject", {30'd0, post_action}, 32'd1);
    begin_move(3, 32'h5000);
    put(8'h05, 1);
    check("R8 phase msg-in", {29'd0, phase}, 32'd7);
    check("R8 post_action cmd", {30'd0, post_action}, 32'd0);
    check("R8 stops parsing", {30'd0, busy, in_ready}, 32'd0);
    check("R8 remaining kept", {8'd0, remaining}, 32'd2);
    idle(2);

    // R8 unknown extended code
    begin_move(4, 32'h6000);
    put(8'h01, 0); put(8'h02, 0); put(8'h07, 1);
    check("R8 ext reject phase", {29'd0, phase}, 32'd7);
    check("R8 ext reject remaining", {8'd0, remaining}, 32'd1);
    check("R8 ext reject idle", {31'd0, busy}, 32'd0);
    idle(2);

    // R10 truncation
    begin_move(1, 32'h7000);
    put(8'h20, 0);
    check("R10 tag truncated", {31'd0, trunc_err}, 32'd1);
    check("R10 idle after truncation", {31'd0, busy}, 32'd0);
    check("R10 tag_valid untouched", {31'd0, tag_valid}, 32'd1);
    begin_move(3, 32'h7100);
    check("R1 start clears trunc", {31'd0, trunc_err}, 32'd0);
    check("R1 start clears unsupported", {31'd0, tag_unsupported}, 32'd0);
    put(8'h01, 0); put(8'h03, 0); put(8'h01, 0);
    check("R10 ext truncated", {31'd0, trunc_err}, 32'd1);

    // R2 hold with gaps, R7 again
    begin_move(2, 32'h8000);
    idle(3);
    check("R2 hold remaining", {8'd0, remaining}, 32'd2);
    check("R2 hold addr", rd_addr, 32'h8000);
    put(8'h83, 0);
    check("R7 lun 3", {29'd0, lun}, 32'd3);
    put(8'h08, 0);
    check("R2 done", {31'd0, busy}, 32'd0);

    // R1 zero count start ignored
    begin_move(0, 32'h9000);
    check("R1 zero count not busy", {30'd0, busy, in_ready}, 32'd0);
    check("R1 zero count phase kept", {29'd0, phase}, 32'd2);
    check("R1 zero count addr kept", rd_addr, 32'h8002);
    cur_cnt = '0;
    idle(3);

    finished = 1;
    report();
    $finish;
  end

endmodule